// File: doc/BRIEF.md
# PCM Transmit Serializer With Frame-Sync Mode Detection

This block sends one PCM sample per frame on a serial data line that is actively driven only while its eight bits are on the wire. A frame-sync input marks each frame and a bit clock paces the bits. Both are sampled by a faster system clock through synchronizers, and their edges are found on the synchronized copies. A parallel sample is written into a holding register by a load strobe. The value held when a frame's output starts is the one that frame sends, so a sample written during a frame goes out in the following frame.

The block works out whether the frame sync is a short pulse (one bit period) or a long one (three or more bit periods). It does this by counting bit-clock falling edges while the sync is high. It then uses the enable timing that matches that style. In short mode the driver turns on at the bit-clock rising edge after a falling edge at which the sync was seen high. In long mode the driver turns on at the later of the sync's rising edge and a bit-clock rising edge. The sign bit (MSB) always leaves first, and the driver turns itself off at the bit-clock falling edge that ends the eighth bit. A permit input from the power controller gates the enable.

Top module: `pcm_tx_serializer`

## Requirements
- R1: After reset `sdo_oe_o` and `sdo_o` are 0 and the block is in short mode, so the first frame uses short-mode enable timing whatever the sync length.
- R2: In short mode, a bit-clock falling edge that sees the sync high (first such edge of a sync pulse) arms the frame. The next bit-clock rising edge raises `sdo_oe_o` and presents bit 7 (MSB) of the sample.
- R3: Each of the next seven bit-clock rising edges presents the next lower bit, ending with bit 0. Between those edges the data line holds its value.
- R4: `sdo_oe_o` falls at the bit-clock falling edge after the rising edge that presented bit 0. Exactly 8 bits are driven, even if the sync is still high.
- R5: In long mode, a sync rising edge that arrives while the bit clock is high enables the output at once with the MSB. If it arrives while the bit clock is low, the output is enabled at the next bit-clock rising edge.
- R6: When the sync falls, the count of bit-clock falling edges seen while it was high sets the mode. A count of 1 selects short, a count of 3 or more selects long, and a count of 2 keeps the current mode. The new mode takes effect from the next frame.
- R7: A frame sends the sample that was held when its output was enabled. A load during a frame changes only the next frame.
- R8: `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R9: While `pwr_permit_i` is 0, `sdo_oe_o` and `sdo_o` stay 0.
- R10: A sync held high for longer than the 8-bit window starts no second frame within the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock, oversampled |
| fsync_i | input | 1 | Transmit frame sync, oversampled |
| smp_i | input | SMP_W | Parallel sample to send |
| smp_load_i | input | 1 | Writes `smp_i` into the holding register |
| pwr_permit_i | input | 1 | Power controller permit, gates the output enable |
| sdo_o | output | 1 | Serial data, MSB first, 0 while disabled |
| sdo_oe_o | output | 1 | Output enable for the serial data driver |

## Verification
The bench runs frames of many sync lengths and tracks the mode in its own model. A design that classifies a two-edge sync wrongly, or that switches mode within the frame being measured, then shows an enable shifted by a bit period. Long-mode syncs start in both bit-clock phases: an implementation that always waits for a rising edge would lose the first bit's head start. Syncs held past the eighth bit catch a design that keeps driving or restarts within the same pulse. A load in mid-frame catches a design that reads the live sample instead of the one captured at enable.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } sync_mode_e;

  // Decide the mode that follows a sync pulse of len falling bit-clock edges.
  function automatic sync_mode_e next_mode(input int unsigned len,
                                           input sync_mode_e cur,
                                           input int unsigned long_min);
    if (len == 1)
      return MODE_SHORT;
    else if (len >= long_min)
      return MODE_LONG;
    else
      return cur;
  endfunction

  // Width needed to count up to n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pcm_sync_mode_det.sv
module pcm_sync_mode_det
  import pcm_tx_pkg::*;
#(
  parameter int unsigned LONG_MIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_lvl_i,
  input  logic       fs_rise_i,
  input  logic       fs_fall_i,
  input  logic       bclk_fall_i,
  output sync_mode_e mode_o
);

  localparam int unsigned CW  = cnt_width(LONG_MIN);
  localparam logic [CW-1:0] CAP = CW'(LONG_MIN);

  logic [CW-1:0] len_q;
  sync_mode_e    mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= MODE_SHORT;
    end else begin
      if (fs_rise_i)
        len_q <= bclk_fall_i ? CW'(1) : '0;
      else if (fs_lvl_i && bclk_fall_i && len_q != CAP)
        len_q <= len_q + 1'b1;
      if (fs_fall_i)
        mode_q <= next_mode(int'(len_q), mode_q, LONG_MIN);
    end
  end

  assign mode_o = mode_q;

  // R6: the mode only moves when a sync pulse ends
  p_mode_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_fall_i |=> $stable(mode_q));

  // R6: the measured length never exceeds its saturation value
  p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= CAP);

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_lvl_i,
  input  logic             bclk_rise_i,
  input  logic             bclk_fall_i,
  input  logic             fs_lvl_i,
  input  logic             fs_rise_i,
  input  sync_mode_e       mode_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_load_i,
  output logic             oe_o,
  output logic             bit_o
);

  localparam int unsigned CW = cnt_width(SMP_W);
  localparam logic [CW-1:0] LAST = CW'(SMP_W);

  logic [SMP_W-1:0] hold_q;
  logic [SMP_W-1:0] shreg_q;
  logic [CW-1:0]    sent_q;
  logic             oe_q;
  logic             bit_q;
  logic             armed_q;
  logic             started_q;

  // Named internal events
  logic trig_short;
  logic trig_long;
  logic en_evt;
  logic shift_evt;
  logic stop_evt;

  assign trig_short = (mode_i == MODE_SHORT) && fs_lvl_i && bclk_fall_i && !started_q;
  assign trig_long  = (mode_i == MODE_LONG) && fs_rise_i && !started_q;
  assign en_evt     = (armed_q && bclk_rise_i) || (trig_long && bclk_lvl_i);
  assign shift_evt  = oe_q && bclk_rise_i && (sent_q != LAST);
  assign stop_evt   = oe_q && bclk_fall_i && (sent_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (smp_load_i) hold_q <= smp_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (!fs_lvl_i)
        started_q <= 1'b0;
      else if (trig_short || trig_long)
        started_q <= 1'b1;
      if (en_evt)
        armed_q <= 1'b0;
      else if (trig_short || (trig_long && !bclk_lvl_i))
        armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      sent_q  <= '0;
      oe_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else if (en_evt) begin
      shreg_q <= hold_q << 1;
      sent_q  <= CW'(1);
      oe_q    <= 1'b1;
      bit_q   <= hold_q[SMP_W-1];
    end else if (shift_evt) begin
      shreg_q <= shreg_q << 1;
      sent_q  <= sent_q + 1'b1;
      bit_q   <= shreg_q[SMP_W-1];
    end else if (stop_evt) begin
      sent_q  <= '0;
      oe_q    <= 1'b0;
      bit_q   <= 1'b0;
    end
  end

  assign oe_o  = oe_q;
  assign bit_o = bit_q;

  // R2: the first bit of a frame is the MSB of the held sample
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> bit_q == $past(hold_q[SMP_W-1]));

  // R5: the output turns on only while the bit clock is high
  p_en_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(bclk_lvl_i));

  // R3: the data bit holds between rising bit-clock edges
  p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !bclk_rise_i && !en_evt && !bclk_fall_i) |=> $stable(bit_q));

  // R4: the output turns off only on a falling bit-clock edge
  p_off_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(bclk_fall_i));

  // R4: never more than the sample width of bits per frame
  p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (sent_q >= CW'(1) && sent_q <= LAST));

  // R8: data is quiet while disabled
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !bit_q);

endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SMP_W       = 8,
  parameter int unsigned LONG_MIN    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_load_i,
  input  logic             pwr_permit_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);

  logic       bclk_lvl, bclk_rise, bclk_fall;
  logic       fs_lvl, fs_rise, fs_fall;
  sync_mode_e mode;
  logic       oe_int, bit_int;

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_i     (bclk_i),
    .level_o (bclk_lvl),
    .rise_o  (bclk_rise),
    .fall_o  (bclk_fall)
  );

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_i     (fsync_i),
    .level_o (fs_lvl),
    .rise_o  (fs_rise),
    .fall_o  (fs_fall)
  );

  pcm_sync_mode_det #(.LONG_MIN(LONG_MIN)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .fs_lvl_i    (fs_lvl),
    .fs_rise_i   (fs_rise),
    .fs_fall_i   (fs_fall),
    .bclk_fall_i (bclk_fall),
    .mode_o      (mode)
  );

  pcm_tx_shifter #(.SMP_W(SMP_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_lvl_i  (bclk_lvl),
    .bclk_rise_i (bclk_rise),
    .bclk_fall_i (bclk_fall),
    .fs_lvl_i    (fs_lvl),
    .fs_rise_i   (fs_rise),
    .mode_i      (mode),
    .smp_i       (smp_i),
    .smp_load_i  (smp_load_i),
    .oe_o        (oe_int),
    .bit_o       (bit_int)
  );

  assign sdo_oe_o = oe_int & pwr_permit_i;
  assign sdo_o    = bit_int & pwr_permit_i;

  // R1: the block leaves reset in short mode
  p_reset_mode_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> mode == MODE_SHORT);

  // R10: once enabled, the enable does not re-rise while the same sync stays high
  p_single_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_int) && fs_lvl) |=> !oe_int);

endmodule

// File: tb/pcm_tx_serializer_tb_top.sv
module pcm_tx_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 8;
  localparam int SMP_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bclk_i = 1'b0;
  logic             fsync_i = 1'b0;
  logic [SMP_W-1:0] smp_i = '0;
  logic             smp_load_i = 1'b0;
  logic             pwr_permit_i = 1'b1;
  logic             sdo_o;
  logic             sdo_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model state
  bit               m_long = 1'b0;
  logic [SMP_W-1:0] m_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_tx_serializer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk_i),
    .fsync_i      (fsync_i),
    .smp_i        (smp_i),
    .smp_load_i   (smp_load_i),
    .pwr_permit_i (pwr_permit_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected enable and data for half-period h of a frame enabled at half e.
  function automatic bit exp_on(input int h, input int e, input bit permit);
    return permit && (h >= e) && (h <= e + 2*SMP_W - 2);
  endfunction

  function automatic bit exp_bit(input int h, input int e, input bit permit,
                                 input logic [SMP_W-1:0] s);
    if (!exp_on(h, e, permit)) return 1'b0;
    return s[SMP_W-1 - (h - e)/2];
  endfunction

  // One bit-clock half period with optional sync change and optional load.
  task automatic half(input bit hi, input bit fs_set, input bit fs_val,
                      input bit do_load, input logic [SMP_W-1:0] ld_val,
                      input bit e_oe, input bit e_sdo, input string req);
    bclk_i = hi;
    @(negedge clk);
    if (fs_set) fsync_i = fs_val;
    if (do_load) begin smp_i = ld_val; smp_load_i = 1'b1; end
    @(negedge clk);
    smp_load_i = 1'b0;
    repeat (HALF_CLKS - 6) @(negedge clk);
    check(sdo_oe_o == e_oe, {req, " oe"}, sdo_oe_o, e_oe);
    check(sdo_o == e_sdo, (e_oe ? {req, " data"} : "R8 data idle"), sdo_o, e_sdo);
    repeat (4) @(negedge clk);
  endtask

  // One frame: len = falling bit-clock edges seen with sync high.
  task automatic run_frame(input int len, input bit low_start, input bit permit,
                           input bit preload, input logic [SMP_W-1:0] smp,
                           input bit midload, input logic [SMP_W-1:0] nxt,
                           input string tag);
    int e, hd, h0, nh;
    logic [SMP_W-1:0] used;
    if (!m_long) low_start = 1'b0;
    if (preload) begin
      smp_i = smp; smp_load_i = 1'b1;
      @(negedge clk);
      smp_load_i = 1'b0;
      m_hold = smp;
    end
    used = m_hold;
    pwr_permit_i = permit;
    h0 = low_start ? 1 : 0;
    hd = 2 * (len + (low_start ? 1 : 0));
    e  = (m_long && !low_start) ? 0 : 2;
    nh = (hd + 2 > e + 2*SMP_W + 2) ? hd + 2 : e + 2*SMP_W + 2;
    for (int h = 0; h < nh; h++) begin
      bit fs_set, fs_val, ld;
      string req;
      bit on;
      fs_set = (h == h0) || (h == hd);
      fs_val = (h == h0);
      ld     = midload && (h == e + 4);
      on     = exp_on(h, e, permit);
      if (!permit) req = "R9";
      else if (h < e) req = m_long ? "R5" : "R2";
      else if (h == e) req = m_long ? "R5" : "R2";
      else if (on) req = "R3";
      else req = (hd > e + 2*SMP_W - 1) ? "R10" : "R4";
      half(h[0] == 1'b0, fs_set, fs_val, ld, nxt, on,
           exp_bit(h, e, permit, used), {tag, "/", req});
    end
    if (midload) m_hold = nxt;
    if (len == 1) m_long = 1'b0;
    else if (len >= 3) m_long = 1'b1;
    pwr_permit_i = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    check(sdo_oe_o == 1'b0, "R1 reset oe", sdo_oe_o, 0);
    check(sdo_o == 1'b0, "R1 reset data", sdo_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdo_oe_o == 1'b0, "R1 idle oe", sdo_oe_o, 0);

    // First frame after reset uses short timing despite a long sync
    run_frame(3, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 8'h00, "R1");
    run_frame(4, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, "R5");
    run_frame(4, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 8'h00, "R5");
    run_frame(2, 1'b0, 1'b1, 1'b1, 8'h7E, 1'b0, 8'h00, "R6");
    run_frame(1, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b0, 8'h00, "R6");
    run_frame(2, 1'b0, 1'b1, 1'b1, 8'h96, 1'b0, 8'h00, "R6");
    run_frame(1, 1'b0, 1'b1, 1'b1, 8'hF0, 1'b1, 8'h0F, "R7");
    run_frame(1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
    run_frame(10, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, "R10");
    run_frame(10, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 8'h00, "R10");
    run_frame(3, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, "R9");

    for (int i = 0; i < 24; i++) begin
      int lens[6] = '{1, 2, 3, 4, 6, 10};
      int len;
      len = lens[$urandom_range(0, 5)];
      run_frame(len, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0),
                ($urandom_range(0, 3) != 0), 8'($urandom),
                ($urandom_range(0, 3) == 0), 8'($urandom), "RND");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule